// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller for a dual-slope integrating converter with a three-and-a-half digit decimal readout. It steps through three phases in a loop. The first is an auto-zero phase of fixed length. The second is a signal-integration phase that lasts exactly one decade of counts (1000 clocks with the default parameters). The third is a reference-integration phase that runs until the comparator reports that the integrator has returned to zero. For each phase it drives exactly one analog switch select. In the reference phase it also chooses the reference polarity.

One cascaded BCD counter times every phase. The counter is cleared at each phase change and counts up once per clock. When the comparator changes state during the reference phase, the count at that moment is the conversion result. That count and the input sign go into output latches, which hold them until the next conversion finishes. A one-clock strobe marks each update. If the reference phase reaches full scale (two decades of counts) without a zero crossing, the controller latches an overrange flag and a blanking code, then starts the next cycle.

The integrator, the comparator circuit and the display are outside this block.

Top module: `dslope_seq`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) gives the following state on the next cycle. `sw_az_o` is 1. `sw_in_o` and `sw_ref_o` are 0. `reading_o` is 0. `neg_o`, `ovr_o` and `valid_o` are 0.
- R2: The auto-zero phase lasts exactly `AZ_CYCLES` clocks, counted from the end of reset or from the end of the previous conversion. During this phase only `sw_az_o` is high. Then signal integration starts. `AZ_CYCLES` must lie in 1 to 2·10^DIGITS.
- R3: Signal integration lasts exactly 10^DIGITS clocks, and during it only `sw_in_o` is high. `cmp_i` is ignored on every integration cycle except the last.
- R4: The value of `cmp_i` on the last integration cycle gives the polarity. A value of 1 means a positive input: `ref_neg_o` is 1 throughout reference integration, and the result latches `neg_o`=0. A value of 0 means a negative input: `ref_neg_o` is 0 and `neg_o` is latched to 1.
- R5: During reference integration only `sw_ref_o` is high, and the counter restarts at 0. Take the first cycle on which `cmp_i` differs from the sampled polarity, and let N be the count on that cycle. The phase then ends after N+1 clocks, `reading_o` takes the BCD value of N, and `ovr_o` is 0. Nibble i (bits 4i+3:4i) holds the decimal digit of weight 10^i. The top nibble is the half digit, 0 or 1.
- R6: Suppose no crossing is seen within 2·10^DIGITS reference clocks. Then the phase ends after exactly that many clocks, `reading_o` becomes all ones, and `ovr_o` is 1. A crossing on the last of those cycles still gives the in-range reading 2·10^DIGITS−1.
- R7: `reading_o`, `neg_o` and `ovr_o` change only on the cycle that `valid_o` marks. Otherwise they hold through the whole next conversion.
- R8: `valid_o` is high for exactly one cycle per completed conversion. That cycle is the first one on which the new values are visible.
- R9: The next auto-zero phase begins right after a conversion ends, so the `valid_o` cycle is the first auto-zero cycle.
- R10: A reset in the middle of a conversion abandons it and clears the latches as in R1. A full auto-zero phase follows the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmp_i | input | 1 | Integrator comparator; 1 = output on the positive-input side |
| sw_az_o | output | 1 | Auto-zero switch select |
| sw_in_o | output | 1 | Signal input switch select |
| sw_ref_o | output | 1 | Reference switch select |
| ref_neg_o | output | 1 | Reference polarity; 1 = negative reference |
| reading_o | output | 4·DIGITS+4 | Latched BCD result, half digit in top nibble |
| neg_o | output | 1 | Latched sign; 1 = negative input |
| ovr_o | output | 1 | Latched overrange flag |
| valid_o | output | 1 | One-cycle strobe on latch update |

## Verification
The bench builds the block with DIGITS=2 and AZ_CYCLES=8. That gives a full scale of 200 counts and an integration phase of 100 clocks, so one conversion takes about 310 clocks at most. At that size the bench can sweep every in-range reading from 0 to 199 with alternating polarity and check each BCD digit carry. It also runs random readings past full scale, the crossing on the very last reference cycle, and a reset in the middle of a conversion, all within the cycle budget.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [1:0] {
        PH_ZERO  = 2'd0,
        PH_SIG   = 2'd1,
        PH_REF   = 2'd2
    } phase_e;

    // Binary to packed BCD, eight nibbles, least significant digit in bits 3:0.
    function automatic logic [31:0] to_bcd(input int unsigned v);
        logic [31:0] r;
        int unsigned t;
        r = '0;
        t = v;
        for (int i = 0; i < 8; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

endpackage

// File: rtl/dslope_bcd_digit.sv
module dslope_bcd_digit #(
    parameter int LAST = 9
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       clr_i,
    input  logic       inc_i,
    output logic [3:0] val_o
);

    logic [3:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (clr_i) begin
            val_d = '0;
        end else if (inc_i) begin
            val_d = (val_q == 4'(LAST)) ? 4'd0 : val_q + 4'd1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign val_o = val_q;

    // R5: a digit never leaves its decimal range
    assert_digit_range_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        val_q <= 4'(LAST));

endmodule

// File: rtl/dslope_bcd_counter.sv
module dslope_bcd_counter #(
    parameter int DIGITS = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  clr_i,
    input  logic                  en_i,
    output logic [4*DIGITS+3:0]   count_o
);

    logic [DIGITS:0] carry;

    assign carry[0] = en_i;

    for (genvar g = 0; g <= DIGITS; g++) begin : g_digit
        localparam int LIM = (g == DIGITS) ? 1 : 9;

        dslope_bcd_digit #(
            .LAST (LIM)
        ) u_digit (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .clr_i (clr_i),
            .inc_i (carry[g]),
            .val_o (count_o[4*g +: 4])
        );

        if (g < DIGITS) begin : g_carry
            assign carry[g+1] = carry[g] && (count_o[4*g +: 4] == 4'd9);
        end
    end

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq #(
    parameter int AZ_CYCLES = 1000,
    parameter int DIGITS    = 3
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                cmp_i,
    output logic                sw_az_o,
    output logic                sw_in_o,
    output logic                sw_ref_o,
    output logic                ref_neg_o,
    output logic [4*DIGITS+3:0] reading_o,
    output logic                neg_o,
    output logic                ovr_o,
    output logic                valid_o
);
    import dslope_pkg::*;

    localparam int W      = 4 * DIGITS + 4;
    localparam int DECADE = 10 ** DIGITS;
    localparam int SCALE  = 2 * DECADE;

    localparam logic [W-1:0] ZERO_LAST = W'(to_bcd(AZ_CYCLES - 1));
    localparam logic [W-1:0] SIG_LAST  = W'(to_bcd(DECADE - 1));
    localparam logic [W-1:0] REF_LAST  = W'(to_bcd(SCALE - 1));

    typedef struct packed {
        phase_e         phase;
        logic           pos;
        logic [W-1:0]   reading;
        logic           neg;
        logic           ovr;
        logic           valid;
    } seq_t;

    seq_t          s_d, s_q;
    logic          clr_w;
    logic [W-1:0]  count_w;

    dslope_bcd_counter #(
        .DIGITS (DIGITS)
    ) u_count (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (clr_w),
        .en_i    (1'b1),
        .count_o (count_w)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        clr_w     = 1'b0;
        unique case (s_q.phase)
            PH_ZERO: begin
                if (count_w == ZERO_LAST) begin
                    s_d.phase = PH_SIG;
                    clr_w     = 1'b1;
                end
            end
            PH_SIG: begin
                if (count_w == SIG_LAST) begin
                    s_d.phase = PH_REF;
                    s_d.pos   = cmp_i;
                    clr_w     = 1'b1;
                end
            end
            PH_REF: begin
                if (cmp_i != s_q.pos) begin
                    s_d.reading = count_w;
                    s_d.ovr     = 1'b0;
                    s_d.neg     = ~s_q.pos;
                    s_d.valid   = 1'b1;
                    s_d.phase   = PH_ZERO;
                    clr_w       = 1'b1;
                end else if (count_w == REF_LAST) begin
                    s_d.reading = '1;
                    s_d.ovr     = 1'b1;
                    s_d.neg     = ~s_q.pos;
                    s_d.valid   = 1'b1;
                    s_d.phase   = PH_ZERO;
                    clr_w       = 1'b1;
                end
            end
            default: begin
                s_d.phase = PH_ZERO;
                clr_w     = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.phase   <= PH_ZERO;
            s_q.pos     <= 1'b0;
            s_q.reading <= '0;
            s_q.neg     <= 1'b0;
            s_q.ovr     <= 1'b0;
            s_q.valid   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sw_az_o   = (s_q.phase == PH_ZERO);
    assign sw_in_o   = (s_q.phase == PH_SIG);
    assign sw_ref_o  = (s_q.phase == PH_REF);
    assign ref_neg_o = sw_ref_o && s_q.pos;
    assign reading_o = s_q.reading;
    assign neg_o     = s_q.neg;
    assign ovr_o     = s_q.ovr;
    assign valid_o   = s_q.valid;

    // R1: reset state
    assert_reset_state_R1: assert property (@(posedge clk_i)
        rst_i |=> (sw_az_o && !sw_in_o && !sw_ref_o && reading_o == '0
                   && !neg_o && !ovr_o && !valid_o));

    // R2: auto-zero ends only at its programmed length
    assert_zero_len_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(sw_az_o) |-> ($past(count_w) == ZERO_LAST && sw_in_o));

    // R3: integration ends only after one decade of counts
    assert_sig_len_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(sw_in_o) && !$past(rst_i)) |-> ($past(count_w) == SIG_LAST && sw_ref_o));

    // R4: reference sign follows the comparator at the end of integration
    assert_ref_sign_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sw_ref_o) |-> (ref_neg_o == $past(cmp_i)));

    // R5: an in-range result is the count at the crossing
    assert_result_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(sw_ref_o) && !$past(rst_i) && !ovr_o)
            |-> (reading_o == $past(count_w) && neg_o == !$past(ref_neg_o)));

    // R6: reference phase never runs past full scale
    assert_ref_bound_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        sw_ref_o |-> (count_w <= REF_LAST));

    // R6: overrange always carries the blanking code
    assert_ovr_code_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ovr_o |-> (reading_o == '1));

    // R7: latches hold between strobes
    assert_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!valid_o && !$past(rst_i))
            |-> ($stable(reading_o) && $stable(neg_o) && $stable(ovr_o)));

    // R8: strobe lasts a single cycle
    assert_strobe_once_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |=> !valid_o);

    // R9: end of conversion strobes and restarts auto-zero together
    assert_restart_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(sw_ref_o) && !$past(rst_i)) |-> (valid_o && sw_az_o));

endmodule

// File: tb/dslope_seq_bench.sv
`timescale 1ns/1ps
module dslope_seq_bench;

    localparam int D     = 2;
    localparam int AZ    = 8;
    localparam int DEC   = 100;
    localparam int FULL  = 200;
    localparam int W     = 4 * D + 4;

    logic         clk_i = 1'b0;
    logic         rst_i = 1'b1;
    logic         cmp_i = 1'b0;
    logic         sw_az_o, sw_in_o, sw_ref_o, ref_neg_o;
    logic [W-1:0] reading_o;
    logic         neg_o, ovr_o, valid_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int            az_pre   = 0;
    bit            have_last = 1'b0;
    logic [W-1:0]  last_rd;
    logic          last_neg;

    always #2.5 clk_i = ~clk_i;

    dslope_seq #(
        .AZ_CYCLES (AZ),
        .DIGITS    (D)
    ) u_dslope_seq (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .cmp_i     (cmp_i),
        .sw_az_o   (sw_az_o),
        .sw_in_o   (sw_in_o),
        .sw_ref_o  (sw_ref_o),
        .ref_neg_o (ref_neg_o),
        .reading_o (reading_o),
        .neg_o     (neg_o),
        .ovr_o     (ovr_o),
        .valid_o   (valid_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_bcd(input int m);
        logic [W-1:0] r;
        int t;
        if (m >= FULL) return '1;
        r = '0;
        t = m;
        for (int i = 0; i <= D; i++) begin
            r[4*i +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic check_reset_state(input string req);
        chk(sw_az_o && !sw_in_o && !sw_ref_o, req, "switches after reset",
            int'({sw_az_o, sw_in_o, sw_ref_o}), 4);
        chk(reading_o == '0, req, "reading after reset", int'(reading_o), 0);
        chk(!neg_o && !ovr_o && !valid_o, req, "flags after reset",
            int'({neg_o, ovr_o, valid_o}), 0);
    endtask

    // One conversion with crossing at reference count m (m >= FULL: never crosses).
    task automatic do_conv(input int m, input bit pos);
        int azc = az_pre;
        int sc  = 0;
        int rc  = 0;
        int bad = 0;
        int exp_rc;
        while (sw_az_o) begin
            if (sw_in_o || sw_ref_o) bad++;
            cmp_i = 1'($urandom);
            azc++;
            @(negedge clk_i);
        end
        chk(azc == AZ, "R2", "auto-zero length", azc, AZ);
        if (have_last)
            chk(reading_o == last_rd && neg_o == last_neg, "R7", "hold during next conversion",
                int'(reading_o), int'(last_rd));
        while (sw_in_o) begin
            if (sw_az_o || sw_ref_o) bad++;
            cmp_i = (sc == DEC - 1) ? pos : 1'($urandom);
            sc++;
            @(negedge clk_i);
        end
        chk(sc == DEC, "R3", "integration length", sc, DEC);
        chk(bad == 0, "R3", "single switch per phase", bad, 0);
        chk(ref_neg_o == pos, "R4", "reference polarity", int'(ref_neg_o), int'(pos));
        while (sw_ref_o) begin
            cmp_i = (rc >= m) ? ~pos : pos;
            rc++;
            @(negedge clk_i);
        end
        exp_rc = (m < FULL) ? m + 1 : FULL;
        chk(rc == exp_rc, (m < FULL) ? "R5" : "R6", "reference length", rc, exp_rc);
        chk(valid_o == 1'b1, "R8", "strobe on update", int'(valid_o), 1);
        chk(sw_az_o == 1'b1, "R9", "auto-zero restarts", int'(sw_az_o), 1);
        chk(reading_o == exp_bcd(m), (m < FULL) ? "R5" : "R6", "reading",
            int'(reading_o), int'(exp_bcd(m)));
        chk(ovr_o == (m >= FULL), "R6", "overrange flag", int'(ovr_o), int'(m >= FULL));
        chk(neg_o == !pos, "R4", "sign latch", int'(neg_o), int'(!pos));
        last_rd   = reading_o;
        last_neg  = neg_o;
        have_last = 1'b1;
        @(negedge clk_i);
        chk(valid_o == 1'b0, "R8", "strobe single cycle", int'(valid_o), 0);
        chk(reading_o == last_rd, "R7", "hold after strobe", int'(reading_o), int'(last_rd));
        az_pre = 1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_i = 1'b1;
        repeat (3) @(negedge clk_i);
        check_reset_state("R1");
        rst_i = 1'b0;
        @(negedge clk_i);
        az_pre = 1;

        // Directed corners
        do_conv(0, 1'b1);
        do_conv(0, 1'b0);
        do_conv(FULL - 1, 1'b1);
        do_conv(FULL - 1, 1'b0);
        do_conv(FULL, 1'b1);
        do_conv(FULL + 7, 1'b0);
        do_conv(DEC - 1, 1'b1);
        do_conv(DEC, 1'b0);
        do_conv(9, 1'b1);
        do_conv(10, 1'b0);

        // Sweep of every in-range reading
        for (int m = 0; m < FULL; m++) begin
            do_conv(m, 1'(m));
        end

        // Random mix including overrange
        for (int k = 0; k < 40; k++) begin
            do_conv(int'($urandom_range(0, FULL + 20)), 1'($urandom));
        end

        // R10: reset in the middle of integration
        while (!sw_in_o) @(negedge clk_i);
        repeat (37) @(negedge clk_i);
        rst_i = 1'b1;
        @(negedge clk_i);
        check_reset_state("R10");
        rst_i     = 1'b0;
        have_last = 1'b0;
        az_pre    = 0;
        do_conv(123, 1'b0);
        do_conv(45, 1'b1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog expired act=0 exp=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule